// File: doc/BRIEF.md
# Branch Direction Prediction Table

This block holds a direct-mapped array of two-bit saturating direction counters, one per entry. Each entry also has a valid bit. The entry is chosen by a few low bits of a branch's virtual PC. The front end uses the lookup port: when the pre-decoder finds a conditional branch at a fetch PC, it raises a lookup request. In the same cycle the table answers with a hit flag and a taken/not-taken prediction.

The execute stage uses the update port. It presents the PC of a resolved conditional branch together with its real outcome. The selected entry is trained on the next clock edge.

The table has no flush input. Trained entries survive pipeline flushes and mispredicts, and only reset clears them. The entry count is a parameter. A count of zero removes the storage entirely, and the outputs are then tied low.

Top module: `branch_dir_table`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `lkp_hit_o` = 0 and `lkp_taken_o` = 0 until the first update.
- R2: `lkp_hit_o` is high only while `lkp_valid_i` is high and the selected entry is valid. Both lookup outputs follow the table combinationally in the same cycle. `lkp_taken_o` is low whenever `lkp_hit_o` is low.
- R3: An update to an invalid entry makes it valid. Its counter starts at 2'b10 (weakly taken) for a taken outcome and at 2'b01 (weakly not taken) for a not-taken outcome.
- R4: An update to a valid entry moves its counter one step: up for taken, down for not taken. The counter saturates at 2'b11 and at 2'b00.
- R5: On a hit, `lkp_taken_o` equals bit 1 of the selected counter. A single opposite outcome therefore flips a weak state but not a strong one.
- R6: The entry index is `pc[OFFS +: log2(ENTRIES)]`. OFFS is 1 when `COMPRESSED` = 1 and 2 otherwise. All other PC bits are ignored, so PCs that differ only outside this field share an entry.
- R7: When a lookup and an update select the same entry in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle on.
- R8: While `upd_valid_i` is low, the table does not change, whatever `upd_pc_i` and `upd_taken_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Pre-decoder found a conditional branch at `lkp_pc_i` |
| lkp_pc_i | input | PC_W | Virtual PC of the branch being looked up |
| lkp_hit_o | output | 1 | The selected entry is valid |
| lkp_taken_o | output | 1 | Predicted direction (1 = taken) |
| upd_valid_i | input | 1 | Execute stage resolved a conditional branch |
| upd_pc_i | input | PC_W | Virtual PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome (1 = taken) |

## Verification
Lookup results are due in the same cycle as the request. Update effects are due exactly one cycle after the update is presented. The driver sets both ports just after a falling edge and pushes the expected lookup result, computed from the bench's own model of the table, into a queue. It then applies any update to that model, so the expected result always reflects the pre-update state. The monitor pops and compares a quarter period later, still before the next rising edge, which keeps the same-cycle read-before-write case of R7 exact.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

    typedef struct packed {
        logic       vld;
        logic [1:0] ctr;
    } bdt_entry_t;

    localparam logic [1:0] CTR_STRONG_NT = 2'b00;
    localparam logic [1:0] CTR_WEAK_NT   = 2'b01;
    localparam logic [1:0] CTR_WEAK_T    = 2'b10;
    localparam logic [1:0] CTR_STRONG_T  = 2'b11;

endpackage

// File: rtl/bdt_index.sv
module bdt_index #(
    parameter int PC_W  = 32,
    parameter int OFFS  = 1,
    parameter int IDX_W = 4
) (
    input  logic [PC_W-1:0]  pc_i,
    output logic [IDX_W-1:0] idx_o
);
    logic unused_pc_bits;

    assign idx_o          = pc_i[OFFS +: IDX_W];
    assign unused_pc_bits = ^pc_i;
endmodule

// File: rtl/bdt_train.sv
module bdt_train
    import bdt_pkg::*;
(
    input  bdt_entry_t cur_i,
    input  logic       taken_i,
    output bdt_entry_t nxt_o
);
    always_comb begin
        nxt_o.vld = 1'b1;
        if (!cur_i.vld) begin
            nxt_o.ctr = taken_i ? CTR_WEAK_T : CTR_WEAK_NT;
        end else if (taken_i) begin
            nxt_o.ctr = (cur_i.ctr == CTR_STRONG_T) ? CTR_STRONG_T : cur_i.ctr + 2'd1;
        end else begin
            nxt_o.ctr = (cur_i.ctr == CTR_STRONG_NT) ? CTR_STRONG_NT : cur_i.ctr - 2'd1;
        end
    end
endmodule

// File: rtl/bdt_read.sv
module bdt_read
    import bdt_pkg::*;
(
    input  bdt_entry_t ent_i,
    input  logic       req_i,
    output logic       hit_o,
    output logic       taken_o
);
    assign hit_o   = req_i & ent_i.vld;
    assign taken_o = hit_o & ent_i.ctr[1];
endmodule

// File: rtl/branch_dir_table.sv
module branch_dir_table
    import bdt_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int PC_W       = 32,
    parameter bit COMPRESSED = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            lkp_valid_i,
    input  logic [PC_W-1:0] lkp_pc_i,
    output logic            lkp_hit_o,
    output logic            lkp_taken_o,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i
);
    localparam int OFFS  = COMPRESSED ? 1 : 2;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    generate
        if (ENTRIES == 0) begin : g_absent
            logic unused_inputs;
            assign unused_inputs = ^{clk_i, rst_ni, lkp_valid_i, lkp_pc_i,
                                     upd_valid_i, upd_pc_i, upd_taken_i};
            assign lkp_hit_o     = 1'b0;
            assign lkp_taken_o   = 1'b0;
        end else begin : g_table
            bdt_entry_t       tbl_d [ENTRIES];
            bdt_entry_t       tbl_q [ENTRIES];
            logic [IDX_W-1:0] lkp_idx;
            logic [IDX_W-1:0] upd_idx;
            bdt_entry_t       upd_next;

            bdt_index #(.PC_W(PC_W), .OFFS(OFFS), .IDX_W(IDX_W)) i_lkp_index (
                .pc_i  (lkp_pc_i),
                .idx_o (lkp_idx)
            );

            bdt_index #(.PC_W(PC_W), .OFFS(OFFS), .IDX_W(IDX_W)) i_upd_index (
                .pc_i  (upd_pc_i),
                .idx_o (upd_idx)
            );

            bdt_train i_train (
                .cur_i   (tbl_q[upd_idx]),
                .taken_i (upd_taken_i),
                .nxt_o   (upd_next)
            );

            bdt_read i_read (
                .ent_i   (tbl_q[lkp_idx]),
                .req_i   (lkp_valid_i),
                .hit_o   (lkp_hit_o),
                .taken_o (lkp_taken_o)
            );

            always_comb begin
                tbl_d = tbl_q;
                if (upd_valid_i) begin
                    tbl_d[upd_idx] = upd_next;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        tbl_q[i] <= '0;
                    end
                end else begin
                    tbl_q <= tbl_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bdt_checker.sv
module bdt_checker #(
    parameter int PC_W = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            lkp_valid_i,
    input logic [PC_W-1:0] lkp_pc_i,
    input logic            lkp_hit_o,
    input logic            lkp_taken_o,
    input logic            upd_valid_i,
    input logic [PC_W-1:0] upd_pc_i,
    input logic            upd_taken_i
);
    logic seen_upd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_upd_q <= 1'b0;
        end else if (upd_valid_i) begin
            seen_upd_q <= 1'b1;
        end
    end

    AST_NO_HIT_BEFORE_TRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_upd_q |-> !lkp_hit_o); // R1

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lkp_valid_i |-> !lkp_hit_o); // R2

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lkp_hit_o |-> !lkp_taken_o); // R2

    AST_WEAK_INIT_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_valid_i && lkp_valid_i && lkp_pc_i == upd_pc_i && !lkp_hit_o)
        ##1 (lkp_valid_i && lkp_pc_i == $past(upd_pc_i))
        |-> lkp_hit_o && (lkp_taken_o == $past(upd_taken_i))); // R3

    AST_UPDATE_VISIBLE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i ##1 (lkp_valid_i && lkp_pc_i == $past(upd_pc_i))
        |-> lkp_hit_o); // R7

    AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lkp_valid_i && !upd_valid_i) ##1 (lkp_valid_i && $stable(lkp_pc_i))
        |-> $stable(lkp_hit_o) && $stable(lkp_taken_o)); // R8
endmodule

bind branch_dir_table bdt_checker #(.PC_W(PC_W)) i_bdt_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_valid_i (lkp_valid_i),
    .lkp_pc_i    (lkp_pc_i),
    .lkp_hit_o   (lkp_hit_o),
    .lkp_taken_o (lkp_taken_o),
    .upd_valid_i (upd_valid_i),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i)
);

// File: tb/test_branch_dir_table.sv
module test_branch_dir_table;
    localparam int ENTRIES = 16;
    localparam int PC_W    = 32;

    typedef struct {
        logic  hit;
        logic  tk;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lkp_valid = 1'b0;
    logic [PC_W-1:0] lkp_pc = '0;
    logic            lkp_hit;
    logic            lkp_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    logic       m_vld [ENTRIES];
    logic [1:0] m_ctr [ENTRIES];

    always #10 clk = ~clk;

    branch_dir_table #(.ENTRIES(ENTRIES), .PC_W(PC_W), .COMPRESSED(1'b1)) i_branch_dir_table (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .lkp_valid_i (lkp_valid),
        .lkp_pc_i    (lkp_pc),
        .lkp_hit_o   (lkp_hit),
        .lkp_taken_o (lkp_taken),
        .upd_valid_i (upd_valid),
        .upd_pc_i    (upd_pc),
        .upd_taken_i (upd_taken)
    );

    // R6: index field is pc[1 +: 4] with compressed support and 16 entries
    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'((pc >> 1) & (ENTRIES - 1));
    endfunction

    task automatic step(input logic lv, input logic [PC_W-1:0] lpc,
                        input logic uv, input logic [PC_W-1:0] upc,
                        input logic ut, input string tag);
        exp_t e;
        int   li;
        int   ui;
        @(negedge clk);
        lkp_valid = lv;
        lkp_pc    = lpc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        li    = idx_of(lpc);
        e.hit = lv && m_vld[li];
        e.tk  = e.hit && m_ctr[li][1];
        e.tag = tag;
        sb_q.push_back(e);
        if (uv) begin
            ui = idx_of(upc);
            if (!m_vld[ui]) begin
                m_vld[ui] = 1'b1;
                m_ctr[ui] = ut ? 2'b10 : 2'b01;
            end else if (ut) begin
                if (m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'd1;
            end else begin
                if (m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'd1;
            end
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string tag);
        step(1'b1, pc, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic train(input logic [PC_W-1:0] pc, input logic t, input string tag);
        step(1'b0, '0, 1'b1, pc, t, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_checks++;
                if (lkp_hit !== e.hit || lkp_taken !== e.tk) begin
                    n_fail++;
                    $display("FAIL %s: hit/taken got %b/%b expected %b/%b",
                             e.tag, lkp_hit, lkp_taken, e.hit, e.tk);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 1'b0;
            m_ctr[i] = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing valid after reset
        look(32'h0000_0000, "R1");
        look(32'h0000_001E, "R1");
        look(32'h8000_1234, "R1");

        // R3: first update sets weak state in the outcome's direction
        train(32'h0000_1000, 1'b1, "R3");
        look(32'h0000_1000, "R3");
        train(32'h0000_1004, 1'b0, "R3");
        look(32'h0000_1004, "R3");

        // R5: weak state flips on one opposite outcome
        train(32'h0000_1000, 1'b0, "R5");
        look(32'h0000_1000, "R5");
        train(32'h0000_1004, 1'b1, "R5");
        look(32'h0000_1004, "R5");

        // R4: saturation at strongly taken, then two steps to flip
        train(32'h0000_2008, 1'b1, "R4");
        for (int k = 0; k < 4; k++) train(32'h0000_2008, 1'b1, "R4");
        train(32'h0000_2008, 1'b0, "R4");
        look(32'h0000_2008, "R4");
        train(32'h0000_2008, 1'b0, "R4");
        look(32'h0000_2008, "R4");
        for (int k = 0; k < 4; k++) train(32'h0000_2008, 1'b0, "R4");
        train(32'h0000_2008, 1'b1, "R4");
        look(32'h0000_2008, "R4");

        // R6: aliasing through bits outside the index field
        train(32'h0000_300C, 1'b1, "R6");
        look(32'h0000_300C + 32'(ENTRIES * 2), "R6");
        look(32'h0000_300D, "R6");
        look(32'hFFF0_000C, "R6");
        look(32'h0000_300E, "R6");

        // R7: same-cycle lookup and update return the old value
        step(1'b1, 32'h0000_4010, 1'b1, 32'h0000_4010, 1'b0, "R7");
        look(32'h0000_4010, "R7");
        step(1'b1, 32'h0000_4010, 1'b1, 32'h0000_4010, 1'b1, "R7");
        look(32'h0000_4010, "R7");

        // R8: disabled update port changes nothing
        step(1'b1, 32'h0000_1004, 1'b0, 32'h0000_1004, 1'b0, "R8");
        step(1'b1, 32'h0000_1004, 1'b0, 32'h0000_1004, 1'b0, "R8");
        look(32'h0000_1004, "R8");

        // R2: no hit without a lookup request, even on a trained entry
        step(1'b0, 32'h0000_1004, 1'b0, '0, 1'b0, "R2");
        step(1'b0, 32'h0000_300C, 1'b1, 32'h0000_300C, 1'b1, "R2");

        // R4 R6 R7: mixed random traffic against the model
        for (int k = 0; k < 300; k++) begin
            step(1'($urandom), 32'($urandom) & 32'h0000_00FF,
                 1'($urandom), 32'($urandom) & 32'h0000_00FF,
                 1'($urandom), "R4");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule